// File: doc/BRIEF.md
# Four-Symbol Class-Driven NFA Matcher

This block scans a byte stream for a regular expression, four bytes per clock. It keeps the active-state set of a position automaton as a bitmap. Each accepted beat of four bytes is first reduced to a small class number. A table of byte patterns performs this reduction. Each pattern may ignore any of its four byte slots, and the pattern that cares about the most bytes wins.

The class number then selects two things. It picks, for every state, the set of states reached after the four symbols have been consumed. It also picks a bitmap that marks the states from which those four symbols complete a match somewhere inside the window. The new active set is the union of the successor sets of all active states. A match is flagged when any active state has its bit set in the match bitmap.

A stream ends with a beat marked last. That beat may carry one to four valid bytes, and the empty slots are filled with a configurable padding byte before classification. The completion of the stream is reported, and the automaton is rearmed for the next stream. All tables are loaded through write ports by surrounding logic.

Top module: `ecnfa_matcher`

## Requirements
- R1: After reset the active set holds only state 0, and `out_hit` and `out_done` are low.
- R2: On each accepted beat, the next active set is the union of successor rows H(x, class) over all active states x.
- R3: Symbol i of a beat is `in_data[8i+7:8i]`, with i=0 first. An enabled pattern entry hits when every byte slot whose care bit i is set equals byte i of its value.
- R4: When several entries hit, the entry with the most care bits set supplies the class. Among entries with equal counts, the lowest entry index wins.
- R5: When no enabled entry hits, the beat takes the class on `cfg_dflt_class`.
- R6: `out_hit` is high in the cycle after an accepted beat exactly when some state active before that beat has its bit set in the match row of the beat's class. This covers a match that ends inside the window.
- R7: On a last beat with `in_bytes` of 1 to 3, the byte slots from `in_bytes` up to 3 are replaced with `cfg_pad_byte` before classification. With `in_bytes` of 4 the beat is used whole.
- R8: `out_done` is high in the cycle after a last beat, together with that beat's hit result. The next beat then starts from the active set {state 0}.
- R9: While `in_valid` is low, the active set is held and `out_hit` and `out_done` are low in the following cycle.
- R10: A pattern entry written with `cfg_pat_en` low never hits until it is rewritten with the bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pat_we | input | 1 | Pattern entry write strobe |
| cfg_pat_idx | input | 5 | Pattern entry index |
| cfg_pat_en | input | 1 | Entry enable written with the entry |
| cfg_pat_value | input | 32 | Four pattern bytes, slot 0 in the low byte |
| cfg_pat_care | input | 4 | Per-slot compare enable |
| cfg_pat_class | input | 4 | Class produced by the entry |
| cfg_dflt_class | input | 4 | Class used when no entry hits |
| cfg_pad_byte | input | 8 | Filler for empty slots of a short last beat |
| cfg_nxt_we | input | 1 | Successor row write strobe |
| cfg_nxt_state | input | 4 | Source state of the row |
| cfg_nxt_class | input | 4 | Class of the row |
| cfg_nxt_row | input | 16 | Successor state set |
| cfg_fin_we | input | 1 | Match row write strobe |
| cfg_fin_class | input | 4 | Class of the match row |
| cfg_fin_row | input | 16 | States from which the class completes a match |
| in_valid | input | 1 | Beat present |
| in_data | input | 32 | Four symbols |
| in_last | input | 1 | Final beat of the stream |
| in_bytes | input | 3 | Valid bytes on the final beat, 1 to 4 |
| out_hit | output | 1 | Match found in the previous beat |
| out_done | output | 1 | Previous beat closed a stream |

## Verification
A short final beat can complete a match. In that case the padding, the match report and the stream-end rearm all fall into the same cycle. The bench provokes this by sending a full beat and then a two-byte last beat whose padded form is the only pattern that reaches a match. It expects `out_hit` and `out_done` to be high together. It then opens a new stream with a beat that would report a match only if the pre-rearm states had survived, and it expects no hit there. Specificity is judged by the successor states each class leaves behind. A probe beat afterwards reveals which class won.

// File: rtl/ecnfa_pkg.sv
package ecnfa_pkg;
  localparam int SYM_W  = 8;
  localparam int GRP    = 4;
  localparam int WORD_W = SYM_W * GRP;

  function automatic logic [2:0] care_count(input logic [GRP-1:0] m);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < GRP; i++) n = n + 3'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/ecnfa_class_sel.sv
module ecnfa_class_sel
  import ecnfa_pkg::*;
#(
  parameter int NPAT   = 32,
  parameter int NCLASS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NPAT)-1:0]   wr_idx,
  input  logic                      wr_on,
  input  logic [WORD_W-1:0]         wr_value,
  input  logic [GRP-1:0]            wr_care,
  input  logic [$clog2(NCLASS)-1:0] wr_cls,
  input  logic [$clog2(NCLASS)-1:0] dflt_cls,
  input  logic [WORD_W-1:0]         grp_i,
  output logic [$clog2(NCLASS)-1:0] cls_o
);
  localparam int PW = $clog2(NPAT);
  localparam int CW = $clog2(NCLASS);

  logic [NPAT-1:0]   ent_on_q, ent_on_d;
  logic [WORD_W-1:0] ent_val  [NPAT];
  logic [GRP-1:0]    ent_care [NPAT];
  logic [CW-1:0]     ent_cls  [NPAT];

  logic [NPAT-1:0] hit;
  logic [2:0]      cnt [NPAT];

  // enable bits: next-state and register processes
  always_comb begin
    ent_on_d = ent_on_q;
    if (wr_en) ent_on_d[wr_idx] = wr_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_on_q <= '0;
    else        ent_on_q <= ent_on_d;
  end

  // entry payload, no reset (gated by enable bits)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_val[wr_idx]  <= wr_value;
      ent_care[wr_idx] <= wr_care;
      ent_cls[wr_idx]  <= wr_cls;
    end
  end

  for (genvar gi = 0; gi < NPAT; gi++) begin : g_ent
    logic [GRP-1:0] slot_ok;
    always_comb begin
      for (int b = 0; b < GRP; b++)
        slot_ok[b] = !ent_care[gi][b] ||
                     (ent_val[gi][b*SYM_W +: SYM_W] == grp_i[b*SYM_W +: SYM_W]);
    end
    assign hit[gi] = ent_on_q[gi] && (&slot_ok);
    assign cnt[gi] = care_count(ent_care[gi]);
  end

  // priority: most care bits, ties to lowest index
  logic          sel_found;
  logic [2:0]    sel_cnt;
  logic [PW-1:0] sel_idx;

  always_comb begin
    sel_found = 1'b0;
    sel_cnt   = '0;
    sel_idx   = '0;
    for (int i = 0; i < NPAT; i++) begin
      if (hit[i] && (!sel_found || cnt[i] > sel_cnt)) begin
        sel_found = 1'b1;
        sel_cnt   = cnt[i];
        sel_idx   = PW'(i);
      end
    end
  end

  assign cls_o = sel_found ? ent_cls[sel_idx] : dflt_cls;

  for (genvar gi = 0; gi < NPAT; gi++) begin : g_chk
    AST_MOST_SPECIFIC: assert property (@(posedge clk) disable iff (!rst_n)
      hit[gi] |-> (sel_found && cnt[gi] <= sel_cnt)); // R4
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[gi] && cnt[gi] == sel_cnt) |-> (PW'(gi) >= sel_idx)); // R4
  end

  AST_DEFAULT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (cls_o == dflt_cls)); // R5
endmodule

// File: rtl/ecnfa_step.sv
module ecnfa_step
  import ecnfa_pkg::*;
#(
  parameter int NSTATE = 16,
  parameter int NCLASS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nxt_we,
  input  logic [$clog2(NSTATE)-1:0] nxt_state,
  input  logic [$clog2(NCLASS)-1:0] nxt_cls,
  input  logic [NSTATE-1:0]         nxt_row,
  input  logic                      fin_we,
  input  logic [$clog2(NCLASS)-1:0] fin_cls,
  input  logic [NSTATE-1:0]         fin_row,
  input  logic [NSTATE-1:0]         act_i,
  input  logic [$clog2(NCLASS)-1:0] cls_i,
  output logic [NSTATE-1:0]         next_o,
  output logic                      hit_o
);
  logic [NSTATE-1:0] h_tbl [NSTATE][NCLASS];
  logic [NSTATE-1:0] f_tbl [NCLASS];

  always_ff @(posedge clk) begin
    if (nxt_we) h_tbl[nxt_state][nxt_cls] <= nxt_row;
    if (fin_we) f_tbl[fin_cls] <= fin_row;
  end

  always_comb begin
    next_o = '0;
    for (int x = 0; x < NSTATE; x++)
      if (act_i[x]) next_o = next_o | h_tbl[x][cls_i];
  end

  assign hit_o = |(act_i & f_tbl[cls_i]);

  AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == '0) |-> (next_o == '0 && !hit_o)); // R2
endmodule

// File: rtl/ecnfa_matcher.sv
module ecnfa_matcher
  import ecnfa_pkg::*;
#(
  parameter int NSTATE = 16,
  parameter int NCLASS = 16,
  parameter int NPAT   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_pat_we,
  input  logic [$clog2(NPAT)-1:0]   cfg_pat_idx,
  input  logic                      cfg_pat_en,
  input  logic [31:0]               cfg_pat_value,
  input  logic [3:0]                cfg_pat_care,
  input  logic [$clog2(NCLASS)-1:0] cfg_pat_class,
  input  logic [$clog2(NCLASS)-1:0] cfg_dflt_class,
  input  logic [7:0]                cfg_pad_byte,
  input  logic                      cfg_nxt_we,
  input  logic [$clog2(NSTATE)-1:0] cfg_nxt_state,
  input  logic [$clog2(NCLASS)-1:0] cfg_nxt_class,
  input  logic [NSTATE-1:0]         cfg_nxt_row,
  input  logic                      cfg_fin_we,
  input  logic [$clog2(NCLASS)-1:0] cfg_fin_class,
  input  logic [NSTATE-1:0]         cfg_fin_row,
  input  logic                      in_valid,
  input  logic [31:0]               in_data,
  input  logic                      in_last,
  input  logic [2:0]                in_bytes,
  output logic                      out_hit,
  output logic                      out_done
);
  localparam int CW = $clog2(NCLASS);
  localparam logic [NSTATE-1:0] INIT_SET = NSTATE'(1);

  // pad short final beat
  logic [2:0]        keep_len;
  logic [WORD_W-1:0] grp;

  always_comb begin
    keep_len = (in_bytes == 3'd0 || in_bytes > 3'd4) ? 3'd4 : in_bytes;
    for (int b = 0; b < GRP; b++)
      grp[b*SYM_W +: SYM_W] = (in_last && 3'(b) >= keep_len) ?
                              cfg_pad_byte : in_data[b*SYM_W +: SYM_W];
  end

  logic [CW-1:0]     cls;
  logic [NSTATE-1:0] act_q, act_d, step_next;
  logic              step_hit;
  logic              hit_q, hit_d, done_q, done_d;

  ecnfa_class_sel #(.NPAT(NPAT), .NCLASS(NCLASS)) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_pat_we),
    .wr_idx   (cfg_pat_idx),
    .wr_on    (cfg_pat_en),
    .wr_value (cfg_pat_value),
    .wr_care  (cfg_pat_care),
    .wr_cls   (cfg_pat_class),
    .dflt_cls (cfg_dflt_class),
    .grp_i    (grp),
    .cls_o    (cls)
  );

  ecnfa_step #(.NSTATE(NSTATE), .NCLASS(NCLASS)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_we    (cfg_nxt_we),
    .nxt_state (cfg_nxt_state),
    .nxt_cls   (cfg_nxt_class),
    .nxt_row   (cfg_nxt_row),
    .fin_we    (cfg_fin_we),
    .fin_cls   (cfg_fin_class),
    .fin_row   (cfg_fin_row),
    .act_i     (act_q),
    .cls_i     (cls),
    .next_o    (step_next),
    .hit_o     (step_hit)
  );

  always_comb begin
    act_d  = act_q;
    hit_d  = 1'b0;
    done_d = 1'b0;
    if (in_valid) begin
      act_d  = in_last ? INIT_SET : step_next;
      hit_d  = step_hit;
      done_d = in_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= INIT_SET;
      hit_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      hit_q  <= hit_d;
      done_q <= done_d;
    end
  end

  assign out_hit  = hit_q;
  assign out_done = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_hit && !out_done)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(act_q)); // R9
  AST_DONE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (act_q == INIT_SET)); // R8
  AST_NO_HIT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_q == '0) |=> !out_hit); // R6
endmodule

// File: tb/ecnfa_matcher_bench.sv
module ecnfa_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_pat_we, cfg_pat_en, cfg_nxt_we, cfg_fin_we;
  logic [4:0]  cfg_pat_idx;
  logic [31:0] cfg_pat_value;
  logic [3:0]  cfg_pat_care, cfg_pat_class, cfg_dflt_class;
  logic [7:0]  cfg_pad_byte;
  logic [3:0]  cfg_nxt_state, cfg_nxt_class, cfg_fin_class;
  logic [15:0] cfg_nxt_row, cfg_fin_row;
  logic        in_valid, in_last;
  logic [31:0] in_data;
  logic [2:0]  in_bytes;
  logic        out_hit, out_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [7:0] PAD = 8'h00;

  always #5 clk = ~clk;

  ecnfa_matcher u_ecnfa_matcher (.*);

  function automatic logic [31:0] g4(input logic [7:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr_pat(input int idx, input logic en, input logic [31:0] v,
                        input logic [3:0] care, input logic [3:0] cls);
    cfg_pat_we = 1; cfg_pat_idx = 5'(idx); cfg_pat_en = en;
    cfg_pat_value = v; cfg_pat_care = care; cfg_pat_class = cls;
    @(posedge clk); @(negedge clk); cfg_pat_we = 0;
  endtask

  task automatic wr_nxt(input int s, input int c, input logic [15:0] row);
    cfg_nxt_we = 1; cfg_nxt_state = 4'(s); cfg_nxt_class = 4'(c); cfg_nxt_row = row;
    @(posedge clk); @(negedge clk); cfg_nxt_we = 0;
  endtask

  task automatic wr_fin(input int c, input logic [15:0] row);
    cfg_fin_we = 1; cfg_fin_class = 4'(c); cfg_fin_row = row;
    @(posedge clk); @(negedge clk); cfg_fin_we = 0;
  endtask

  task automatic beat(input logic [31:0] d, input logic last, input logic [2:0] nb);
    in_valid = 1; in_data = d; in_last = last; in_bytes = nb;
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic t_reset;
    chk("R1 hit low", out_hit, 1'b0);
    chk("R1 done low", out_done, 1'b0);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R1 only state0 active", out_hit, 1'b0);
  endtask

  task automatic t_basic;
    beat(g4("A","B","C","D"), 0, 3'd4);
    chk("R3 ABCD no hit", out_hit, 1'b0);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R2 R6 state1 then EFGH hit", out_hit, 1'b1);
    chk("R8 no done mid stream", out_done, 1'b0);
  endtask

  task automatic t_break;
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("X","Y","Z","W"), 0, 3'd4);
    chk("R5 default class no hit", out_hit, 1'b0);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R5 default dropped state1", out_hit, 1'b0);
  endtask

  task automatic t_idle;
    beat(g4("A","B","C","D"), 0, 3'd4);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 idle hit low", out_hit, 1'b0);
      chk("R9 idle done low", out_done, 1'b0);
    end
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R9 state held over idle", out_hit, 1'b1);
  endtask

  task automatic t_spec;
    beat(g4("A","B","z","z"), 0, 3'd4);
    beat(g4("P","P","P","P"), 0, 3'd4);
    chk("R4 AB~~ class reached", out_hit, 1'b1);
    beat(g4("z","z","C","D"), 0, 3'd4);
    beat(g4("Q","Q","Q","Q"), 0, 3'd4);
    chk("R4 ~~CD class reached", out_hit, 1'b1);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("P","P","P","P"), 0, 3'd4);
    chk("R4 full pattern beats partial", out_hit, 1'b0);
  endtask

  task automatic t_tie;
    wr_pat(2, 1'b0, g4("A","B","C","D"), 4'b1111, 4'd1);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("Q","Q","Q","Q"), 0, 3'd4);
    chk("R4 R10 tie to lowest index", out_hit, 1'b1);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R10 disabled entry ignored", out_hit, 1'b0);
    wr_pat(2, 1'b1, g4("A","B","C","D"), 4'b1111, 4'd1);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R10 re-enabled entry hits", out_hit, 1'b1);
  endtask

  task automatic t_mid;
    beat(g4("M","N","O","P"), 0, 3'd4);
    chk("R6 match inside window", out_hit, 1'b1);
  endtask

  task automatic t_pad;
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("E","F","z","z"), 1, 3'd2);
    chk("R7 padded last beat hit", out_hit, 1'b1);
    chk("R8 done with hit", out_done, 1'b1);
    beat(g4("E","F","G","H"), 0, 3'd4);
    chk("R8 rearmed after done", out_hit, 1'b0);
    chk("R8 done one cycle", out_done, 1'b0);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("E","F","G","H"), 1, 3'd4);
    chk("R7 full last beat hit", out_hit, 1'b1);
    chk("R8 full last done", out_done, 1'b1);
    beat(g4("A","B","C","D"), 0, 3'd4);
    beat(g4("E","F","z","z"), 1, 3'd3);
    chk("R7 three bytes kept no hit", out_hit, 1'b0);
    chk("R8 done on 3-byte last", out_done, 1'b1);
  endtask

  initial begin
    rst_n = 0;
    cfg_pat_we = 0; cfg_nxt_we = 0; cfg_fin_we = 0;
    cfg_pat_idx = 0; cfg_pat_en = 0; cfg_pat_value = 0; cfg_pat_care = 0; cfg_pat_class = 0;
    cfg_nxt_state = 0; cfg_nxt_class = 0; cfg_nxt_row = 0;
    cfg_fin_class = 0; cfg_fin_row = 0;
    cfg_dflt_class = 4'd0; cfg_pad_byte = PAD;
    in_valid = 0; in_data = 0; in_last = 0; in_bytes = 3'd4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++)
        wr_nxt(s, c, (s == 0) ? 16'h0001 : 16'h0000);
    for (int c = 0; c < 16; c++) wr_fin(c, 16'h0000);
    wr_nxt(0, 1, 16'h0003);
    wr_nxt(1, 2, 16'h0001);
    wr_nxt(0, 3, 16'h0009);
    wr_nxt(0, 4, 16'h0011);
    wr_nxt(0, 8, 16'h0003);
    wr_nxt(1, 8, 16'h0003);
    wr_fin(2, 16'h0002);
    wr_fin(5, 16'h0008);
    wr_fin(6, 16'h0010);
    wr_fin(7, 16'h0001);
    wr_fin(8, 16'h0002);
    wr_pat(0, 1, g4(8'h00, 8'h00, "C", "D"), 4'b1100, 4'd4);
    wr_pat(1, 1, g4("A", "B", 8'h00, 8'h00), 4'b0011, 4'd3);
    wr_pat(2, 1, g4("A","B","C","D"), 4'b1111, 4'd1);
    wr_pat(3, 1, g4("E","F","G","H"), 4'b1111, 4'd2);
    wr_pat(4, 1, g4("P","P","P","P"), 4'b1111, 4'd5);
    wr_pat(5, 1, g4("Q","Q","Q","Q"), 4'b1111, 4'd6);
    wr_pat(6, 1, g4("M","N","O","P"), 4'b1111, 4'd7);
    wr_pat(7, 1, g4("E","F",PAD,PAD), 4'b1111, 4'd8);
    beat(g4("X","X","X","X"), 1, 3'd4);
    t_basic;
    t_break;
    t_idle;
    t_spec;
    t_tie;
    t_mid;
    t_pad;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule